// File: doc/BRIEF.md
# Wait-for-Sync Result Buffer

This block buffers the words produced by a decimating data filter until the processor collects them. Each data-ready strobe from the filter offers one word. The word is stored in a first-in, first-out queue of fixed depth. A fill-count interrupt lets software take a batch of results at once instead of taking an interrupt for every sample. Each word is stored either at full width or as its lower half, sign-extended to full width.

An optional wait-for-sync mode keeps the buffer armed after reset or a clear. While it is armed, every data-ready strobe is discarded. The first external sync pulse disarms it. From then on, every strobe stores a word, so the first stored result lines up with a known control event. A clear empties the queue, clears the sticky overflow flag and arms the wait state again.

The input side has no back-pressure, because the filter cannot stall. A strobe that arrives while the queue is full is dropped and recorded as an overflow. The output side is a valid/ready stream. `out_vld` is high whenever the queue holds a word, and `out_data` then shows the oldest word. A cycle with both `out_vld` and `out_rdy` high removes that word. While `out_rdy` is low, the head word and `out_vld` hold steady.

Top module: `wfs_data_fifo`

## Requirements
- R1: After reset the level is 0, `empty` is 1, `full`, `overflow`, `irq` and `out_vld` are 0, and the wait state is armed.
- R2: Words leave in the order they were stored. `out_data` always shows the oldest stored word while `out_vld` is 1.
- R3: `level` equals the number of stored words, from 0 to 16. `empty` is high exactly at level 0 and `full` exactly at level 16.
- R4: A strobe accepted while full, with no read in the same cycle, drops the word and leaves the level at 16. It sets `overflow`, which stays set until a clear.
- R5: A read and a write in the same cycle at level 16 both take effect: the level stays 16 and `overflow` stays 0. At level 0, a strobe with `out_rdy` high stores the word and no read occurs, so the level becomes 1.
- R6: `irq` is high exactly while the level is at least the effective threshold. `irq_thresh` sets that threshold, 1 to 16. A value of 0 acts as 1 and a value above 16 acts as 16.
- R7: While `wfs_en` is 1 and the buffer is armed, a data-ready strobe without a sync pulse in the same cycle leaves the contents and the level unchanged.
- R8: A sync pulse disarms the buffer. A strobe in the same cycle as the sync pulse is stored, and so is every later strobe.
- R9: A clear empties the buffer, clears `overflow` and re-arms the wait state. It takes priority over a strobe or a read in the same cycle.
- R10: With `fmt16` at 1 at the time of the write, the stored word is `in_data[15:0]` sign-extended to 32 bits. With `fmt16` at 0, the stored word is all 32 bits of `in_data`.
- R11: With `wfs_en` at 0, every strobe is stored whether or not the buffer is armed.
- R12: While `out_vld` is 1 and `out_rdy` is 0, `out_vld` stays 1 and `out_data` holds its value on the next cycle, unless a clear occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Filter result word |
| in_strobe | input | 1 | Data-ready strobe, one word per high cycle |
| fmt16 | input | 1 | 1: store the lower half, sign-extended |
| sync_pulse | input | 1 | External sync event that disarms the wait state |
| wfs_en | input | 1 | Enables discarding of strobes while armed |
| irq_thresh | input | 5 | Fill level at which the interrupt asserts |
| clear | input | 1 | Empty the buffer, clear overflow, re-arm |
| out_data | output | 32 | Oldest stored word |
| out_vld | output | 1 | A word is available |
| out_rdy | input | 1 | Consumer takes the word when out_vld is high |
| level | output | 5 | Number of stored words |
| empty | output | 1 | Level is 0 |
| full | output | 1 | Level is 16 |
| overflow | output | 1 | Sticky: a word was dropped while full |
| irq | output | 1 | Level is at or above the threshold |

## Verification
The bench uses the default parameters, a depth of 16 and a width of 32, so every fill level can be reached in a handful of cycles. It sweeps all sixteen thresholds. For each one it fills the buffer word by word, through full and into overflow, then drains it, which exercises every level/threshold pair and the interrupt on both edges. The small depth also makes the corner cases cheap to reach: simultaneous read and write at both ends, out-of-range thresholds, wait-for-sync arming and clears, and both storage formats, each checked against a queue model in the bench.

// File: rtl/wfs_fifo_pkg.sv
package wfs_fifo_pkg;
  // One cycle's worth of queue operations, as decided by the controller.
  typedef struct packed {
    logic clr;   // flush everything
    logic push;  // a word enters the storage
    logic pop;   // the head word leaves
  } fifo_op_t;
endpackage

// File: rtl/wfs_fifo_mem.sv
module wfs_fifo_mem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/wfs_fifo_ctrl.sv
module wfs_fifo_ctrl
  import wfs_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_strobe,
  input  logic          sync_pulse,
  input  logic          wfs_en,
  input  logic          clear,
  input  logic          out_rdy,
  output fifo_op_t      op,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          overflow
);
  logic armed;
  logic gated, push_req, is_full, is_empty;

  assign is_full  = (count == CW'(DEPTH));
  assign is_empty = (count == '0);
  // a sync in the same cycle releases the strobe that comes with it
  assign gated    = wfs_en & armed & ~sync_pulse;
  assign push_req = in_strobe & ~gated;

  always_comb begin
    op.clr  = clear;
    op.pop  = ~clear & out_rdy & ~is_empty;
    op.push = ~clear & push_req & (~is_full | op.pop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
      armed    <= 1'b1;
    end else if (op.clr) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
      armed    <= 1'b1;
    end else begin
      if (sync_pulse) armed <= 1'b0;
      if (op.push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (op.pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(op.push) - CW'(op.pop);
      if (push_req && is_full && !op.pop) overflow <= 1'b1;
    end
  end

  // R3: the level never leaves its legal range
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R4: a write into a full buffer with no read marks overflow and keeps it full
  a_r4_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && in_strobe && !gated && !out_rdy && !clear) |=> (overflow && is_full));

  // R4: overflow is sticky until a clear
  a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear) |=> overflow);

  // R7: an armed buffer ignores strobes
  a_r7_armed_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !out_rdy && !clear) |=> (count == $past(count)));

  // R9: a clear empties and resets overflow
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0 && !overflow));
endmodule

// File: rtl/wfs_fifo_irq.sv
module wfs_fifo_irq #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] thresh,
  output logic          irq
);
  logic [CW-1:0] eff;

  // out-of-range thresholds are pulled to the nearest legal value
  always_comb begin
    if (thresh == '0)                eff = CW'(1);
    else if (thresh > CW'(DEPTH))    eff = CW'(DEPTH);
    else                             eff = thresh;
  end

  assign irq = (count >= eff);

  // R6: a full buffer always requests service
  a_r6_irq_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> irq);
endmodule

// File: rtl/wfs_data_fifo.sv
module wfs_data_fifo
  import wfs_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int HALF = WIDTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_strobe,
  input  logic             fmt16,
  input  logic             sync_pulse,
  input  logic             wfs_en,
  input  logic [CW-1:0]    irq_thresh,
  input  logic             clear,
  output logic [WIDTH-1:0] out_data,
  output logic             out_vld,
  input  logic             out_rdy,
  output logic [CW-1:0]    level,
  output logic             empty,
  output logic             full,
  output logic             overflow,
  output logic             irq
);
  fifo_op_t         op;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [WIDTH-1:0] wr_word;

  // narrow form keeps the lower half and extends its sign
  assign wr_word = fmt16 ? {{(WIDTH - HALF){in_data[HALF-1]}}, in_data[HALF-1:0]} : in_data;

  wfs_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe), .sync_pulse(sync_pulse),
    .wfs_en(wfs_en), .clear(clear), .out_rdy(out_rdy), .op(op),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(level), .overflow(overflow)
  );

  wfs_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk(clk), .we(op.push), .waddr(wr_ptr), .wdata(wr_word),
    .raddr(rd_ptr), .rdata(out_data)
  );

  wfs_fifo_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .count(level), .thresh(irq_thresh), .irq(irq)
  );

  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign out_vld = ~empty;

  // R6: an interrupt never stands on an empty buffer
  a_r6_irq_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !empty);

  // R12: a stalled consumer sees a steady head word
  a_r12_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy && !clear) |=> (out_vld && $stable(out_data)));

  // R3: full and empty never coincide
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: tb/sim_wfs_data_fifo.sv
module sim_wfs_data_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_strobe = 1'b0, fmt16 = 1'b0, sync_pulse = 1'b0, wfs_en = 1'b0;
  logic [4:0]  irq_thresh = 5'd1;
  logic        clear = 1'b0, out_rdy = 1'b0;
  logic [31:0] out_data;
  logic        out_vld, empty, full, overflow, irq;
  logic [4:0]  level;

  int checks = 0, failures = 0;
  logic [31:0] mq[$];
  logic        m_armed = 1'b1, m_ovf = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wfs_data_fifo u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_strobe(in_strobe), .fmt16(fmt16),
    .sync_pulse(sync_pulse), .wfs_en(wfs_en), .irq_thresh(irq_thresh), .clear(clear),
    .out_data(out_data), .out_vld(out_vld), .out_rdy(out_rdy), .level(level),
    .empty(empty), .full(full), .overflow(overflow), .irq(irq)
  );

  task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tg, act, exp);
    end
  endtask

  function automatic int teff();
    if (irq_thresh == 0) return 1;
    if (irq_thresh > DEPTH) return DEPTH;
    return int'(irq_thresh);
  endfunction

  // compare every output with the bench queue model
  task automatic check_all(input string ctx);
    int n = mq.size();
    chk(level == 5'(n), {"R3 level ", ctx}, 32'(level), 32'(n));
    chk(empty == (n == 0), {"R3 empty ", ctx}, 32'(empty), 32'(n == 0));
    chk(full == (n == DEPTH), {"R3 full ", ctx}, 32'(full), 32'(n == DEPTH));
    chk(overflow == m_ovf, {"R4 overflow ", ctx}, 32'(overflow), 32'(m_ovf));
    chk(irq == (n >= teff()), {"R6 irq ", ctx}, 32'(irq), 32'(n >= teff()));
    chk(out_vld == (n != 0), {"R2 out_vld ", ctx}, 32'(out_vld), 32'(n != 0));
    if (n != 0) chk(out_data == mq[0], {"R2 head ", ctx}, out_data, mq[0]);
  endtask

  // one clock cycle of stimulus, with the model advanced by the requirements
  task automatic step(input logic stb, input logic [31:0] d, input logic f16,
                      input logic sy, input logic rdy, input logic clr);
    logic [31:0] w;
    bit pop, push;
    in_strobe = stb; in_data = d; fmt16 = f16; sync_pulse = sy; out_rdy = rdy; clear = clr;
    @(posedge clk);
    #1;
    in_strobe = 0; sync_pulse = 0; out_rdy = 0; clear = 0;
    w = f16 ? {{16{d[15]}}, d[15:0]} : d;
    if (clr) begin
      mq.delete(); m_ovf = 0; m_armed = 1;
    end else begin
      push = stb && !(wfs_en && m_armed && !sy);
      if (sy) m_armed = 0;
      pop = rdy && mq.size() != 0;
      if (pop) void'(mq.pop_front());
      if (push) begin
        if (mq.size() < DEPTH) mq.push_back(w);
        else m_ovf = 1;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: state straight out of reset
    chk(level == 0 && empty && !full && !overflow && !irq && !out_vld, "R1 reset outputs",
        {27'd0, level}, 32'd0);
    rst_n = 1;
    #1;
    check_all("R1 after reset");

    // R1/R7: reset leaves the buffer armed
    wfs_en = 1;
    step(1, 32'h1111, 0, 0, 0, 0);
    check_all("R1 R7 armed after reset");
    wfs_en = 0;

    // R2 R3 R4 R6: every threshold, fill into overflow, drain
    for (int t = 1; t <= DEPTH; t++) begin
      irq_thresh = 5'(t);
      step(0, 0, 0, 0, 0, 1);
      for (int k = 1; k <= DEPTH + 1; k++) begin
        step(1, 32'hC0DE0000 ^ (t << 8) ^ k, 0, 0, 0, 0);
        check_all("R11 fill");
      end
      for (int k = 1; k <= DEPTH; k++) begin
        step(0, 0, 0, 0, 1, 0);
        check_all("R4 drain");
      end
    end

    // R6: out-of-range thresholds
    irq_thresh = 5'd0;
    step(0, 0, 0, 0, 0, 1);
    step(1, 32'h5, 0, 0, 0, 0);
    check_all("R6 thresh0");
    irq_thresh = 5'd31;
    for (int k = 0; k < DEPTH - 1; k++) begin
      step(1, 32'h100 + k, 0, 0, 0, 0);
      check_all("R6 thresh31");
    end

    // R5: read and write together at full
    step(1, 32'hAAAA5555, 0, 0, 1, 0);
    check_all("R5 full rw");
    for (int k = 0; k < DEPTH; k++) begin
      step(0, 0, 0, 0, 1, 0);
      check_all("R5 drain after rw");
    end
    // R5: read and write together at empty
    step(1, 32'h77, 0, 0, 1, 0);
    check_all("R5 empty rw");

    // R9: clear wins over a same-cycle write
    step(1, 32'h88, 0, 0, 1, 1);
    check_all("R9 clear priority");

    // R7 R8: wait-for-sync
    wfs_en = 1; irq_thresh = 5'd2;
    step(0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 3; k++) begin
      step(1, 32'h900 + k, 0, 0, 0, 0);
      check_all("R7 ignored while armed");
    end
    step(1, 32'hABC, 0, 1, 0, 0);
    check_all("R8 write with sync");
    step(1, 32'hABD, 0, 0, 0, 0);
    check_all("R8 write after sync");
    // R9: clear re-arms
    step(0, 0, 0, 0, 0, 1);
    step(1, 32'hDEAD, 0, 0, 0, 0);
    check_all("R9 rearmed");
    step(0, 0, 0, 1, 0, 0);
    step(1, 32'hBEEF, 0, 0, 0, 0);
    check_all("R8 sync alone");

    // R10: storage formats
    step(1, 32'h0000_8001, 1, 0, 0, 0);
    step(1, 32'h1234_7FFF, 1, 0, 0, 0);
    step(1, 32'h8765_4321, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 0, 0, 1, 0);
      check_all("R10 format");
    end

    // R12: stalled head stays put while writes arrive
    step(1, 32'h4242, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      step(1, 32'h5000 + k, 0, 0, 0, 0);
      chk(out_data == 32'h4242 && out_vld, "R12 head held", out_data, 32'h4242);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule